// File: doc/BRIEF.md
# Slave-Mode Sync Edge Aligner

The block accepts free-running horizontal and vertical sync levels from an external timing source. Both are asynchronous to the sample clock. For each it produces a single-cycle reset pulse on the sample clock, and downstream pixel and line counters restart on those pulses. A sense bit per signal selects whether its rising or its falling transition is the one that matters. A two-bit field holds the horizontal pulse back by zero to three extra clock periods, so the counters can be trimmed against the data stream.

A reference bit states whether the horizontal transition marks the first active sample of a line or the first blanking sample. The block reports this setting as a level that travels with each horizontal pulse. A counter can then preload either 0 or the blanking start position. All settings are written as one control word. A new word does not act at once. It is held pending, and each channel adopts it on that channel's next inactive transition, so a setting change never produces an extra pulse or loses a pulse.

Top module: `sync_edge_aligner`

## Requirements
- R1: With the horizontal sense bit (bit 0) at 1 a rising hsync transition yields one h_reset pulse and a falling one yields none; with it at 0 the roles swap.
- R2: The vertical sense bit (bit 1) selects the vertical active transition the same way, independently of the horizontal one, and each vertical active transition yields exactly one v_reset pulse.
- R3: When an input level is first captured at rising clock edge P0, v_reset is high during the single cycle after edge P0+2.
- R4: The delay field in bits 14:13 adds D clock periods to the horizontal path, so h_reset is high during the single cycle after edge P0+2+D.
- R5: h_ref_blank takes the value of the reference bit (bit 2: 0 for active start, 1 for blanking start) that was in force when the transition was detected, changes only when an h_reset pulse begins, and holds between pulses.
- R6: Inactive transitions of either input produce no pulse.
- R7: A written horizontal sense, delay or reference value takes effect only after the next horizontal inactive transition that is detected under the sense bit in force, and a pulse already in flight keeps the delay it started with.
- R8: While rst_n is low and right after it is released, h_reset, v_reset, h_ref_blank and cfg_rdata are all 0, and the adopted settings are all 0.
- R9: cfg_rdata returns the last written word with every bit outside fields 14:13, 2, 1 and 0 read as 0.
- R10: A written vertical sense value takes effect only after the next vertical inactive transition that is detected under the vertical sense bit in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | External horizontal sync level, asynchronous |
| vsync_in | input | 1 | External vertical sync level, asynchronous |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word to write |
| cfg_rdata | output | 16 | Pending control word, undefined bits zero |
| h_reset | output | 1 | Aligned horizontal reset pulse |
| v_reset | output | 1 | Aligned vertical reset pulse |
| h_ref_blank | output | 1 | 1 when the last h_reset marks blanking start |

## Verification
A wrong edge-detector state shows as a missing or duplicated pulse three cycles after the input transition. A corrupted delay tag in the horizontal pipeline shows as a pulse one to three cycles away from the expected position, or as two pulses. A wrongly adopted setting only shows on the next transition of that channel. The bench therefore follows every write with transitions in both directions and measures the exact pulse position each time. A stale reference tag shows at h_ref_blank on the same cycle as the pulse it rides with.

// File: rtl/sea_pkg.sv
package sea_pkg;

  // True when the pair (cur, prev) is the transition chosen by rise_sel.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise_sel);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Mask covering the defined fields of the control word.
  function automatic logic [15:0] field_mask16(input int dly_lsb, input int dly_w,
                                               input int hs_bit, input int vs_bit,
                                               input int ref_bit);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < dly_w; i++) m[dly_lsb + i] = 1'b1;
    m[hs_bit]  = 1'b1;
    m[vs_bit]  = 1'b1;
    m[ref_bit] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sea_edge_chan.sv
module sea_edge_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic rise_sel,
  output logic lvl,
  output logic act_edge,
  output logic inact_edge
);
  import sea_pkg::*;

  logic [SYNC_STAGES-1:0] sr_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[SYNC_STAGES-2:0], async_in};
      prev_q <= sr_q[SYNC_STAGES-1];
    end
  end

  assign lvl        = sr_q[SYNC_STAGES-1];
  assign act_edge   = edge_hit(lvl, prev_q, rise_sel);
  assign inact_edge = edge_hit(lvl, prev_q, ~rise_sel);

endmodule

// File: rtl/sea_cfg_reg.sv
module sea_cfg_reg #(
  parameter int CFG_W      = 16,
  parameter int DLY_LSB    = 13,
  parameter int DLY_W      = 2,
  parameter int HSENSE_BIT = 0,
  parameter int VSENSE_BIT = 1,
  parameter int REF_BIT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             p_hsense,
  output logic             p_vsense,
  output logic [DLY_W-1:0] p_dly,
  output logic             p_ref
);
  import sea_pkg::*;

  localparam logic [15:0] MASK16 = field_mask16(DLY_LSB, DLY_W, HSENSE_BIT, VSENSE_BIT, REF_BIT);
  localparam logic [CFG_W-1:0] MASK = MASK16[CFG_W-1:0];

  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= wdata & MASK;
  end

  assign rdata    = word_q;
  assign p_hsense = word_q[HSENSE_BIT];
  assign p_vsense = word_q[VSENSE_BIT];
  assign p_ref    = word_q[REF_BIT];
  assign p_dly    = word_q[DLY_LSB +: DLY_W];

endmodule

// File: rtl/sea_hdelay.sv
module sea_hdelay #(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_in,
  input  logic [DLY_W-1:0] dly_in,
  input  logic             ref_in,
  output logic             pulse_out,
  output logic             ref_out
);
  localparam int MAX_DLY = (1 << DLY_W) - 1;

  logic [MAX_DLY:1] v_q;
  logic [MAX_DLY:1] r_q;
  logic [DLY_W-1:0] d_q [1:MAX_DLY];
  logic [MAX_DLY:1] hit;
  logic             zero_fire;
  logic             pulse_nxt;
  logic             ref_nxt;

  // Each stage fires when its own carried delay equals its depth.
  for (genvar g = 1; g <= MAX_DLY; g++) begin : g_tap
    assign hit[g] = v_q[g] && (d_q[g] == DLY_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      r_q <= '0;
      for (int i = 1; i <= MAX_DLY; i++) d_q[i] <= '0;
    end else begin
      v_q[1] <= fire_in && (dly_in != '0);
      d_q[1] <= dly_in;
      r_q[1] <= ref_in;
      for (int i = 2; i <= MAX_DLY; i++) begin
        v_q[i] <= v_q[i-1] && !hit[i-1];
        d_q[i] <= d_q[i-1];
        r_q[i] <= r_q[i-1];
      end
    end
  end

  always_comb begin
    zero_fire = fire_in && (dly_in == '0);
    pulse_nxt = zero_fire || (|hit);
    ref_nxt   = ref_out;
    for (int i = MAX_DLY; i >= 1; i--) begin
      if (hit[i]) ref_nxt = r_q[i];
    end
    if (zero_fire) ref_nxt = ref_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_out <= 1'b0;
      ref_out   <= 1'b0;
    end else begin
      pulse_out <= pulse_nxt;
      ref_out   <= ref_nxt;
    end
  end

endmodule

// File: rtl/sync_edge_aligner.sv
module sync_edge_aligner #(
  parameter int CFG_W       = 16,
  parameter int DLY_LSB     = 13,
  parameter int DLY_W       = 2,
  parameter int HSENSE_BIT  = 0,
  parameter int VSENSE_BIT  = 1,
  parameter int REF_BIT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             h_reset,
  output logic             v_reset,
  output logic             h_ref_blank
);

  logic             p_hsense, p_vsense, p_ref;
  logic [DLY_W-1:0] p_dly;

  logic             h_sense_act, v_sense_act, h_ref_act;
  logic [DLY_W-1:0] h_dly_act;

  logic h_lvl, h_act_edge, h_inact_edge;
  logic v_lvl, v_act_edge, v_inact_edge;

  sea_cfg_reg #(
    .CFG_W(CFG_W), .DLY_LSB(DLY_LSB), .DLY_W(DLY_W),
    .HSENSE_BIT(HSENSE_BIT), .VSENSE_BIT(VSENSE_BIT), .REF_BIT(REF_BIT)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .p_hsense(p_hsense), .p_vsense(p_vsense), .p_dly(p_dly), .p_ref(p_ref)
  );

  sea_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) hchan_i (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in), .rise_sel(h_sense_act),
    .lvl(h_lvl), .act_edge(h_act_edge), .inact_edge(h_inact_edge)
  );

  sea_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) vchan_i (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .rise_sel(v_sense_act),
    .lvl(v_lvl), .act_edge(v_act_edge), .inact_edge(v_inact_edge)
  );

  // Pending settings are adopted only on each channel's inactive transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_sense_act <= 1'b0;
      h_dly_act   <= '0;
      h_ref_act   <= 1'b0;
    end else if (h_inact_edge) begin
      h_sense_act <= p_hsense;
      h_dly_act   <= p_dly;
      h_ref_act   <= p_ref;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            v_sense_act <= 1'b0;
    else if (v_inact_edge) v_sense_act <= p_vsense;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_reset <= 1'b0;
    else        v_reset <= v_act_edge;
  end

  sea_hdelay #(.DLY_W(DLY_W)) hdly_i (
    .clk(clk), .rst_n(rst_n), .fire_in(h_act_edge), .dly_in(h_dly_act),
    .ref_in(h_ref_act), .pulse_out(h_reset), .ref_out(h_ref_blank)
  );

endmodule

// File: rtl/sync_edge_aligner_chk.sv
module sync_edge_aligner_chk #(
  parameter int DLY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             h_reset,
  input logic             v_reset,
  input logic             h_ref_blank,
  input logic             h_act_edge,
  input logic             h_inact_edge,
  input logic             v_act_edge,
  input logic             v_inact_edge,
  input logic             v_lvl,
  input logic             h_sense_act,
  input logic [DLY_W-1:0] h_dly_act,
  input logic             h_ref_act,
  input logic             v_sense_act
);
  localparam logic [DLY_W-1:0] MAXD = '1;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_quiet: assert (!h_reset && !v_reset && !h_ref_blank);
    end
  end

  a_r2_v_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    v_reset |-> ($past(v_lvl) == $past(v_sense_act)));

  a_r6_v_inactive_silent: assert property (@(posedge clk) disable iff (!rst_n)
    v_inact_edge |=> !v_reset);

  a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (h_act_edge && h_dly_act == '0) |=> h_reset);

  a_r4_max_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(h_act_edge, 4) && $past(h_dly_act, 4) == MAXD) |-> h_reset);

  a_r5_flag_tag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(h_act_edge, 4) && $past(h_dly_act, 4) == MAXD) |-> (h_ref_blank == $past(h_ref_act, 4)));

  a_r5_flag_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_ref_blank) |-> h_reset);

  a_r7_h_adopt: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(h_dly_act) || !$stable(h_sense_act) || !$stable(h_ref_act)) |-> $past(h_inact_edge));

  a_r10_v_adopt: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_sense_act) |-> $past(v_inact_edge));

endmodule

bind sync_edge_aligner sync_edge_aligner_chk #(.DLY_W(DLY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .h_reset(h_reset), .v_reset(v_reset),
  .h_ref_blank(h_ref_blank), .h_act_edge(h_act_edge), .h_inact_edge(h_inact_edge),
  .v_act_edge(v_act_edge), .v_inact_edge(v_inact_edge), .v_lvl(v_lvl),
  .h_sense_act(h_sense_act), .h_dly_act(h_dly_act), .h_ref_act(h_ref_act),
  .v_sense_act(v_sense_act)
);

// File: tb/sync_edge_aligner_tb_top.sv
module sync_edge_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic        h_reset, v_reset, h_ref_blank;

  localparam logic [15:0] FMASK = 16'h6007;

  sync_edge_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync), .vsync_in(vsync),
    .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(rd),
    .h_reset(h_reset), .v_reset(v_reset), .h_ref_blank(h_ref_blank)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int ncyc = 0;
  int h_cnt = 0, h_last = -1, h_flag = 0;
  int v_cnt = 0, v_last = -1;

  // Bench model of pending and adopted settings.
  logic [15:0] pend = '0;
  int m_hs = 0, m_hd = 0, m_hr = 0, m_vs = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    if (h_reset) begin h_cnt++; h_last = ncyc; h_flag = int'(h_ref_blank); end
    if (v_reset) begin v_cnt++; v_last = ncyc; end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] word);
    @(posedge clk); #2;
    we = 1'b1; wd = word;
    @(posedge clk); #2;
    we = 1'b0;
    pend = word & FMASK;
    check("R9 readback", int'(rd), int'(word & FMASK));
  endtask

  task automatic toggle_h();
    int t0, c0;
    bit act;
    @(posedge clk); #2;
    hsync = ~hsync;
    t0 = ncyc; c0 = h_cnt;
    act = (m_hs != 0) ? hsync : !hsync;
    repeat (10) @(posedge clk);
    @(negedge clk);
    if (act) begin
      check("R1 one pulse on active h edge", h_cnt - c0, 1);
      check("R4 h latency 3+D", h_last - t0, 3 + m_hd);
      check("R5 reference flag", h_flag, m_hr);
    end else begin
      check("R6 no pulse on inactive h edge", h_cnt - c0, 0);
      m_hs = int'(pend[0]); m_hd = int'(pend[14:13]); m_hr = int'(pend[2]);
    end
  endtask

  task automatic toggle_v();
    int t0, c0;
    bit act;
    @(posedge clk); #2;
    vsync = ~vsync;
    t0 = ncyc; c0 = v_cnt;
    act = (m_vs != 0) ? vsync : !vsync;
    repeat (10) @(posedge clk);
    @(negedge clk);
    if (act) begin
      check("R2 one pulse on active v edge", v_cnt - c0, 1);
      check("R3 v latency 3", v_last - t0, 3);
    end else begin
      check("R6 no pulse on inactive v edge", v_cnt - c0, 0);
      m_vs = int'(pend[1]);
    end
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 h_reset in reset", int'(h_reset), 0);
    check("R8 v_reset in reset", int'(v_reset), 0);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R8 flag after reset", int'(h_ref_blank), 0);
    check("R8 cfg_rdata after reset", int'(rd), 0);

    // R7 / R10: a write alone changes no adopted setting; transitions reveal it.
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [15:0] word;
      word = 16'h9ff8;                                // undefined bits set, must read 0
      word[0] = cfg[0];
      word[14:13] = 2'(cfg >> 1);
      word[2] = cfg[3];
      word[1] = cfg[1] ^ cfg[3];
      wr(word);
      repeat (4) toggle_h();
      repeat (2) toggle_v();
    end

    // R7: pulse in flight keeps delay 3 while delay 0 is adopted behind it.
    wr(16'h6001);
    repeat (2) toggle_h();
    if (hsync) toggle_h();
    begin
      int t0, c0;
      @(posedge clk); #2;
      hsync = 1'b1; t0 = ncyc; c0 = h_cnt;
      wr(16'h0001);
      hsync = 1'b0;
      repeat (10) @(posedge clk);
      @(negedge clk);
      check("R7 in-flight pulse count", h_cnt - c0, 1);
      check("R7 in-flight pulse keeps delay 3", h_last - t0, 6);
      m_hs = 1; m_hd = 0; m_hr = 0;
    end
    toggle_h();
    toggle_h();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule